// File: doc/BRIEF.md
# Manchester Receive Decoder with Preamble Lock

This block takes a single-ended Manchester line sampled by a fast local clock that runs `OSR` times the bit rate. It recovers a one-cycle bit strobe and NRZ serial data from that line. Before decoding, a pulse-width filter removes short noise pulses. The line idles high. A Manchester 1 is low in the first half of its cell and high in the second half. A Manchester 0 is high and then low, so it has a falling edge at mid-cell.

Any clean departure from idle raises carrier sense. The recovery phase counter keeps running freely at the bit rate until the first 0 that follows a 1. That 0 is a falling mid-cell edge one full bit after the previous edge, and it freezes the counter. At the next such 0, which is bit 4 of a 1,0,1,0 lead-in, the counter restarts in phase with that edge and the block counts as locked. From then on, one strobe is issued at the quarter point of every cell, starting in cell 5. The data output carries the bit of the previous cell. Carrier drops when the filtered line shows no transition for more than one and a half bit times.

Top module: `mdec_rx`

## Requirements
- R1: After reset, `crs_o` is 0, `clk_stb_o` is 0 and `rx_data_o` is 1.
- R2: A line pulse of fewer than `GLITCH_MIN` samples (default 2) has no effect: an idle line keeps `crs_o` low, and the data recovered during a packet is unchanged. A pulse of exactly `GLITCH_MIN` samples is accepted.
- R3: `crs_o` rises on the third clock edge after the edge that first samples the line leaving idle.
- R4: Lock needs a 1 followed by a 0, seen twice (the 1,0,1,0 lead-in). A line that carries only Manchester 1s holds carrier but never produces a strobe.
- R5: After a 1,0,1,0 lead-in, `clk_stb_o` pulses for one cycle for each cell from cell 5 onward. Each pulse comes three edges after the edge that samples position `OSR/4` of that cell, so one pulse arrives every `OSR` cycles.
- R6: At each strobe, `rx_data_o` takes the bit decoded at the previous strobe and holds it until the next one. The bit decoded is the inverse of the line level at the cell's quarter point. The first strobe leaves `rx_data_o` at 1, and bit 5 appears at the cell-6 strobe.
- R7: Whenever `crs_o` is low, `rx_data_o` is 1 and `clk_stb_o` is 0.
- R8: Carrier drops on the sixteenth edge after the edge that samples the last line transition, which means 13 samples with no transition. From that point the block is idle again.
- R9: After carrier drops, a new packet is acquired with the same timing as the first one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, OSR times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Manchester line, idle high |
| crs_o | output | 1 | Carrier sense |
| clk_stb_o | output | 1 | One-cycle recovered bit strobe |
| rx_data_o | output | 1 | Recovered NRZ data, high when idle |

## Verification
Every output is due a fixed number of edges after the edge that samples the line sample causing it:
- Carrier rise: 3 edges (input register, two filter stages).
- Each strobe, together with its data update: 3 edges after the quarter-point sample.
- Carrier drop: 16 edges after the last transition.

The bench drives one line sample and reads the outputs at each falling edge. The value read at falling edge j therefore reflects the rising edge after sample j-1. The expected value for each cycle is derived from the sample index of the packet start, the cell quarter points and the last clean transition. Glitches are placed only in the middle of a half-cell, so they never move a real edge and the expected timing stays exact.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    // Acquisition progress of the receive decoder.
    typedef enum logic [1:0] {
        ACQ_IDLE  = 2'd0,   // no carrier, phase free-running
        ACQ_SEEK0 = 2'd1,   // carrier up, waiting for first 0 after a 1
        ACQ_HOLD  = 2'd2,   // phase frozen, waiting for second 0 after a 1
        ACQ_LOCK  = 2'd3    // phase aligned, strobes and data running
    } acq_state_t;
endpackage

// File: rtl/mdec_glitch_filt.sv
// Pulse-width filter. The output follows the registered input only
// after it has held a new level for MIN_W consecutive samples.
// Assumes: the input is already synchronous to clk; the output resets to IDLE_LVL.
module mdec_glitch_filt #(
    parameter int   MIN_W    = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    logic in_q;

    // Register the raw line once.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= IDLE_LVL;
        else        in_q <= raw_i;
    end

    generate
        if (MIN_W <= 1) begin : g_pass
            // No filtering requested: one more register keeps the latency fixed.
            always_ff @(posedge clk) begin
                if (!rst_n) filt_o <= IDLE_LVL;
                else        filt_o <= in_q;
            end
        end else begin : g_count
            localparam int CW = $clog2(MIN_W) + 1;
            logic [CW-1:0] run_q;

            // Count how long a differing level has persisted; accept it at MIN_W.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    filt_o <= IDLE_LVL;
                    run_q  <= '0;
                end else if (in_q == filt_o) begin
                    run_q  <= '0;
                end else if (run_q == CW'(MIN_W - 1)) begin
                    filt_o <= in_q;
                    run_q  <= '0;
                end else begin
                    run_q  <= run_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mdec_edge_timer.sv
// Transition detector and interval timer on the filtered line.
// It flags transitions and falling edges, and reports whether the current
// interval is one full bit (OSR +/- 1 samples) or longer than TMO samples.
// Assumes: TMO >= OSR + 1.
module mdec_edge_timer #(
    parameter int   OSR      = 8,
    parameter int   TMO      = 12,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_i,
    output logic trans_o,
    output logic fall_o,
    output logic full_gap_o,
    output logic timeout_o
);
    localparam int GW = $clog2(TMO + 2);
    localparam logic [GW-1:0] GAP_SAT = GW'(TMO + 1);

    logic          filt_q;
    logic [GW-1:0] gap_q;

    // Remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_q <= IDLE_LVL;
        else        filt_q <= filt_i;
    end

    // Samples since the last transition, saturating just past the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= '0;
        else if (trans_o)       gap_q <= GW'(1);
        else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
    end

    // Classify the current sample.
    always_comb begin
        trans_o    = (filt_i != filt_q);
        fall_o     = trans_o && !filt_i;
        full_gap_o = (gap_q >= GW'(OSR - 1)) && (gap_q <= GW'(OSR + 1));
        timeout_o  = (gap_q > GW'(TMO));
    end
endmodule

// File: rtl/mdec_acq_ctrl.sv
// Acquisition sequencer and bit-phase counter.
// When idle, the phase counter runs freely at the bit rate. The first 0
// after a 1 freezes it. The second such 0 restarts it aligned to
// mid-cell, and that moment is lock. Once locked, mid-cell edges
// re-centre the counter.
// Assumes: OSR >= 4 and even.
module mdec_acq_ctrl
    import mdec_pkg::*;
#(
    parameter int OSR = 8,
    localparam int PW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trans_i,
    input  logic          fall_i,
    input  logic          full_gap_i,
    input  logic          timeout_i,
    output acq_state_t    state_o,
    output logic [PW-1:0] phase_o
);
    localparam int MID = OSR / 2;

    acq_state_t    state_d;
    logic [PW-1:0] phase_inc;
    logic          zero_seen;
    logic          mid_edge;

    // Next-state decision for acquisition.
    always_comb begin
        zero_seen = fall_i && full_gap_i;
        state_d   = state_o;
        unique case (state_o)
            ACQ_IDLE:  if (trans_i)   state_d = ACQ_SEEK0;
            ACQ_SEEK0: if (timeout_i) state_d = ACQ_IDLE;
                       else if (zero_seen) state_d = ACQ_HOLD;
            ACQ_HOLD:  if (timeout_i) state_d = ACQ_IDLE;
                       else if (zero_seen) state_d = ACQ_LOCK;
            ACQ_LOCK:  if (timeout_i) state_d = ACQ_IDLE;
            default:   state_d = ACQ_IDLE;
        endcase
    end

    // Phase helpers: wrapping increment and mid-cell window test.
    always_comb begin
        phase_inc = (phase_o == PW'(OSR - 1)) ? '0 : phase_o + 1'b1;
        mid_edge  = trans_i && (phase_o >= PW'(MID - 1)) && (phase_o <= PW'(MID + 1));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ACQ_IDLE;
        else        state_o <= state_d;
    end

    // Phase counter: free-run, freeze, align, or track.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
        end else begin
            unique case (state_o)
                ACQ_HOLD: phase_o <= (state_d == ACQ_LOCK) ? PW'(MID + 1) : phase_o;
                ACQ_LOCK: phase_o <= mid_edge ? PW'(MID + 1) : phase_inc;
                default:  phase_o <= phase_inc;
            endcase
        end
    end
endmodule

// File: rtl/mdec_data_out.sv
// Strobe and data stage. While running, it samples the inverted line at
// the quarter point of each cell, pulses the strobe, and presents the bit
// taken one cell earlier. While not running, data is held high and no
// strobe is issued.
// Assumes: phase_i counts sample positions 0..OSR-1 within the cell.
module mdec_data_out #(
    parameter int OSR = 8,
    localparam int PW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [PW-1:0] phase_i,
    input  logic          filt_i,
    output logic          stb_o,
    output logic          data_o
);
    localparam int QTR = OSR / 4;

    logic samp_q;
    logic at_qtr;

    // Quarter-cell sampling point.
    always_comb at_qtr = run_i && (phase_i == PW'(QTR));

    // Strobe, bit capture and one-cell-delayed data output.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            stb_o  <= 1'b0;
            samp_q <= 1'b1;
            data_o <= 1'b1;
        end else begin
            stb_o <= at_qtr;
            if (at_qtr) begin
                samp_q <= ~filt_i;
                data_o <= samp_q;
            end
        end
    end
endmodule

// File: rtl/mdec_rx.sv
// Manchester receive decoder: glitch filter, edge timer, acquisition
// sequencer and data stage in a chain.
// Assumes: the line idles high and clk runs at OSR samples per bit.
module mdec_rx
    import mdec_pkg::*;
#(
    parameter int OSR        = 8,
    parameter int GLITCH_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic crs_o,
    output logic clk_stb_o,
    output logic rx_data_o
);
    localparam int   TMO      = (3 * OSR) / 2;
    localparam int   PW       = $clog2(OSR);
    localparam logic IDLE_LVL = 1'b1;

    logic          filt;
    logic          trans;
    logic          fall;
    logic          full_gap;
    logic          timeout;
    acq_state_t    state;
    logic [PW-1:0] phase;
    logic          run;

    mdec_glitch_filt #(.MIN_W(GLITCH_MIN), .IDLE_LVL(IDLE_LVL)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (rx_in),
        .filt_o (filt)
    );

    mdec_edge_timer #(.OSR(OSR), .TMO(TMO), .IDLE_LVL(IDLE_LVL)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_i     (filt),
        .trans_o    (trans),
        .fall_o     (fall),
        .full_gap_o (full_gap),
        .timeout_o  (timeout)
    );

    mdec_acq_ctrl #(.OSR(OSR)) u_acq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trans_i    (trans),
        .fall_i     (fall),
        .full_gap_i (full_gap),
        .timeout_i  (timeout),
        .state_o    (state),
        .phase_o    (phase)
    );

    // Data runs only while locked and not timing out this cycle.
    always_comb begin
        run   = (state == ACQ_LOCK) && !timeout;
        crs_o = (state != ACQ_IDLE);
    end

    mdec_data_out #(.OSR(OSR)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .phase_i (phase),
        .filt_i  (filt),
        .stb_o   (clk_stb_o),
        .data_o  (rx_data_o)
    );
endmodule

// File: rtl/mdec_rx_chk.sv
// Property checker for mdec_rx, attached by bind.
module mdec_rx_chk #(
    parameter int OSR = 8
) (
    input logic clk,
    input logic rst_n,
    input logic crs_o,
    input logic clk_stb_o,
    input logic rx_data_o
);
    logic [15:0] since_crs;

    // Cycles spent with carrier up, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !crs_o)        since_crs <= '0;
        else if (since_crs != 16'hFFFF) since_crs <= since_crs + 1'b1;
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crs_o |-> (rx_data_o && !clk_stb_o));

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stb_o |=> !clk_stb_o);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crs_o && !clk_stb_o) |-> $stable(rx_data_o));

    // R4
    lock_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stb_o |-> (since_crs >= 16'(4 * OSR)));
endmodule

bind mdec_rx mdec_rx_chk #(.OSR(OSR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .crs_o     (crs_o),
    .clk_stb_o (clk_stb_o),
    .rx_data_o (rx_data_o)
);

// File: tb/mdec_rx_tb.sv
module mdec_rx_tb;
    localparam int OSR  = 8;
    localparam int MAXS = 2048;
    localparam int QOFF = OSR / 4 + 4;   // quarter point plus observe latency

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic rx_in = 1'b1;
    logic crs_o, clk_stb_o, rx_data_o;

    int n_chk = 0;
    int n_bad = 0;

    logic sb [MAXS];
    bit   pbit [0:127];
    int   plen, pbase, plast, pcells;
    bit   plock, pcar;

    always #5 clk = ~clk;

    mdec_rx #(.OSR(OSR), .GLITCH_MIN(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .crs_o     (crs_o),
        .clk_stb_o (clk_stb_o),
        .rx_data_o (rx_data_o)
    );

    task automatic chk(input string req, input int j, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s sample %0d: actual %b expected %b", req, j, act, exp);
        end
    endtask

    function automatic int q_of(input int n);
        return pbase + OSR * (n - 1) + QOFF;
    endfunction

    // Packet: idle lead, Manchester cells, idle tail.
    task automatic build(input int lead, input int ncell, input bit all_ones, input bit glitchy);
        int idx;
        idx = 0;
        for (int i = 0; i < lead; i++) begin sb[idx] = 1'b1; idx++; end
        pbase = lead;
        for (int c = 1; c <= ncell; c++) begin
            bit b;
            if (all_ones)    b = 1'b1;
            else if (c <= 5) b = (c % 2 == 1);
            else             b = 1'($urandom_range(0, 1));
            pbit[c] = b;
            for (int k = 0; k < OSR; k++) begin
                sb[idx] = (k < OSR / 2) ? ~b : b;
                idx++;
            end
        end
        for (int i = 0; i < 8 * OSR; i++) begin sb[idx] = 1'b1; idx++; end
        plen   = idx;
        pcells = ncell;
        plock  = !all_ones && (ncell >= 5);
        pcar   = (ncell > 0);
        plast  = 0;
        for (int i = 1; i < plen; i++) if (sb[i] != sb[i-1]) plast = i;
        if (glitchy) begin
            // R2: single-sample pulses, each inside a half-cell or the idle lead
            sb[lead / 2] = 1'b0;
            for (int c = 6; c <= ncell; c++) begin
                if ($urandom_range(0, 2) == 0) begin
                    int pos;
                    pos = ($urandom_range(0, 1) == 1) ? OSR / 4 : 3 * OSR / 4;
                    sb[pbase + OSR * (c - 1) + pos] = ~sb[pbase + OSR * (c - 1) + pos];
                end
            end
        end
    endtask

    // Isolated low pulse on an idle line.
    task automatic pulse_pkt(input int lead, input int width);
        plen = lead + width + 8 * OSR;
        for (int i = 0; i < plen; i++) sb[i] = 1'b1;
        for (int i = lead; i < lead + width; i++) sb[i] = 1'b0;
        pbase  = lead;
        plast  = lead + width;
        pcells = 0;
        plock  = 1'b0;
        pcar   = (width >= 2);
    endtask

    // Drive one sample per falling edge and check the outputs from the prior rising edge.
    task automatic play(input string crs_req, input string quiet_req);
        for (int j = 0; j < plen; j++) begin
            logic crs_e, stb_e, dat_e;
            int   nl;
            @(negedge clk);
            crs_e = pcar && (j >= pbase + 4) && (j <= plast + 16);
            if (pcar && j > plast + 16) chk("R8", j, crs_o, crs_e);
            else                        chk(crs_req, j, crs_o, crs_e);
            if (plock && j <= q_of(pcells + 1)) begin
                nl = 0;
                for (int n = 5; n <= pcells + 1; n++) if (j >= q_of(n)) nl = n;
                stb_e = (nl != 0) && (j == q_of(nl));
                dat_e = (nl <= 5) ? 1'b1 : pbit[nl - 1];
                chk("R5", j, clk_stb_o, stb_e);
                chk("R6", j, rx_data_o, dat_e);
            end else if (!plock) begin
                chk(quiet_req, j, clk_stb_o, 1'b0);
                chk(quiet_req, j, rx_data_o, 1'b1);
            end else if (j > plast + 16) begin
                chk("R8", j, clk_stb_o, 1'b0);
                chk("R8", j, rx_data_o, 1'b1);
            end
            rx_in = sb[j];
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", 0, crs_o, 1'b0);
        chk("R1", 0, clk_stb_o, 1'b0);
        chk("R1", 0, rx_data_o, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7", 0, rx_data_o, 1'b1);

        pulse_pkt(10, 1);  play("R2", "R2");   // R2: rejected pulse
        pulse_pkt(10, 2);  play("R2", "R2");   // R2: minimum accepted pulse
        build(12, 20, 1'b0, 1'b0); play("R3", "R7");
        build(9, 12, 1'b1, 1'b0);  play("R3", "R4");   // R4: only 1s
        build(8, 5, 1'b0, 1'b0);   play("R3", "R7");   // shortest packet
        build(16, 30, 1'b0, 1'b1); play("R2", "R7");   // glitches in payload
        for (int p = 0; p < 6; p++) begin
            build($urandom_range(8, 40), $urandom_range(6, 40), 1'b0, p[0]);
            play("R9", "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule